// File: doc/BRIEF.md
# Masked Event Status Controller

This block collects interrupt indications from up to 32 internal and external components into one sticky status word. Each status bit has two companions: a hold bit in a clear-control register and a gate bit in a mask register. While a hold bit is 1, its status bit is forced to 0 and new events on that bit are dropped. Writing the hold bit back to 0 resumes capture. Clearing is therefore level-held, not a one-shot write-1-to-clear.

The unmasked status bits are ORed into one interrupt condition. A rising edge of that condition raises a request toward a downstream message-signalled-interrupt generator. The request stays up until that generator acknowledges it. Software reaches the three registers through a simple synchronous read/write port that answers every access one cycle later.

Top module: `evt_status_ctrl`

## Requirements
- R1: An event pulse on `evt_i[n]` that is sampled at a clock edge sets status bit n at that edge, unless hold bit n is 1 after that edge.
- R2: A set status bit stays set until it is cleared through its hold bit. Reading the status register does not change it.
- R3: Writing 1 to hold bit n clears status bit n at the same edge that stores the write.
- R4: While hold bit n is 1, status bit n reads 0 and events on bit n are ignored. This includes an event in the same cycle as the write that sets the hold bit. Writing 0 to hold bit n re-enables capture, and an event in the same cycle as that write is captured.
- R5: A mask bit of 1 keeps its status bit out of the interrupt. A mask bit of 0 lets the status bit through. After reset the mask register is all ones.
- R6: `irq_req_o` rises one edge after the OR of (status AND NOT mask) changes from 0 to 1. This happens for an event and also for a mask write that exposes a bit already set. The request then stays high until a cycle with `irq_ack_i` high, and it is low after that cycle.
- R7: While the masked OR stays 1, no further request is raised, even if more unmasked bits are set. A new request needs the OR to fall to 0 and rise again.
- R8: The registers sit at word offsets from `BASE_ADDR`: status at +0x0 (read-only, writes ignored), hold at +0x4, mask at +0x8. Any other address reads 0 and ignores writes.
- R9: Each read or write cycle gets `reg_ack_o` high in the next cycle. On a read, `reg_rdata_o` shows the register value from the cycle of the request.
- R10: A synchronous active-low reset clears status, hold and the request, and sets the mask to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | EVT_W | Per-bit event pulses from components |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | EVT_W | Write data |
| reg_rdata_o | output | EVT_W | Read data, valid with acknowledge |
| reg_ack_o | output | 1 | Access acknowledge, one cycle after the strobe |
| irq_req_o | output | 1 | Interrupt request to the message generator |
| irq_ack_i | input | 1 | Acknowledge from the message generator |

## Verification
The hardest cases to reach from the ports are the ones where an event and a hold-register write land on the same edge. In one, setting the hold bit must beat the event. In the other, releasing the hold bit must let the event through. The bench drives the event pulse in the same cycle as the register write strobe, then reads the status word back.

The no-retrigger rule is also hard to reach, because it needs the masked OR to stay high across an acknowledge. The bench acknowledges a request and then adds a second unmasked event without clearing the first. It checks that no request follows, then clears the status word and confirms that a fresh event triggers again.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
// Package: shared register selection type and word offsets for the
// event status controller. Offsets are relative to the block base address.
package evt_pkg;
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_HOLD   = 2'd2,
        SEL_MASK   = 2'd3
    } reg_sel_e;

    localparam int OFS_STATUS = 0;
    localparam int OFS_HOLD   = 4;
    localparam int OFS_MASK   = 8;
endpackage

// File: rtl/evt_regport.sv
`timescale 1ns/1ps
// Module: evt_regport
// Decodes the register port and holds the hold (clear-control) and mask
// registers. It returns read data and the acknowledge one cycle after a
// strobe. It also exports the hold value that will be in force after the
// current edge, so that the status bank applies a clear in the same cycle
// as the write.
// Assumes: one access per cycle; the status register is read-only.
module evt_regport
    import evt_pkg::*;
#(
    parameter int                EVT_W     = 32,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1474
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [EVT_W-1:0]  wdata_i,
    input  logic [EVT_W-1:0]  status_i,
    output logic [EVT_W-1:0]  rdata_o,
    output logic              ack_o,
    output logic [EVT_W-1:0]  hold_q_o,
    output logic [EVT_W-1:0]  hold_next_o,
    output logic [EVT_W-1:0]  mask_q_o
);
    localparam logic [ADDR_W-1:0] ADDR_STATUS = BASE_ADDR + ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] ADDR_HOLD   = BASE_ADDR + ADDR_W'(OFS_HOLD);
    localparam logic [ADDR_W-1:0] ADDR_MASK   = BASE_ADDR + ADDR_W'(OFS_MASK);

    reg_sel_e         sel;
    logic [EVT_W-1:0] hold_q, mask_q;

    // Address decode into a register selection.
    always_comb begin
        if (addr_i == ADDR_STATUS)    sel = SEL_STATUS;
        else if (addr_i == ADDR_HOLD) sel = SEL_HOLD;
        else if (addr_i == ADDR_MASK) sel = SEL_MASK;
        else                          sel = SEL_NONE;
    end

    // Hold value in force after this edge, including a write in progress.
    always_comb begin
        hold_next_o = hold_q;
        if (wr_i && sel == SEL_HOLD) hold_next_o = wdata_i;
    end

    // Writable registers: hold clears to 0 on reset, mask sets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            mask_q <= '1;
        end else begin
            hold_q <= hold_next_o;
            if (wr_i && sel == SEL_MASK) mask_q <= wdata_i;
        end
    end

    // Read data and acknowledge, both registered one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
            ack_o   <= 1'b0;
        end else begin
            ack_o <= wr_i | rd_i;
            if (rd_i) begin
                unique case (sel)
                    SEL_STATUS: rdata_o <= status_i;
                    SEL_HOLD:   rdata_o <= hold_q;
                    SEL_MASK:   rdata_o <= mask_q;
                    default:    rdata_o <= '0;
                endcase
            end
        end
    end

    assign hold_q_o = hold_q;
    assign mask_q_o = mask_q;

    // R9: every strobe is acknowledged in the next cycle.
    assert_ack_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i || rd_i) |=> ack_o);
    // R9: no acknowledge without a strobe in the previous cycle.
    assert_no_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i || rd_i) |=> !ack_o);
    // R5: the mask changes only through a write to the mask address.
    assert_mask_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == ADDR_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/evt_status_bank.sv
`timescale 1ns/1ps
// Module: evt_status_bank
// Sticky status bits, one per event line. An event sets its bit. The hold
// value in force after the edge forces the bit to 0, and the hold wins
// over an event in the same cycle.
// Assumes: events are single-cycle pulses synchronous to clk.
module evt_status_bank #(
    parameter int EVT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic [EVT_W-1:0] hold_next_i,
    output logic [EVT_W-1:0] status_o
);
    logic [EVT_W-1:0] status_q;

    for (genvar b = 0; b < EVT_W; b++) begin : g_bit
        // Per-bit sticky capture with held clear taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n)              status_q[b] <= 1'b0;
            else if (hold_next_i[b]) status_q[b] <= 1'b0;
            else if (evt_i[b])       status_q[b] <= 1'b1;
        end
    end

    assign status_o = status_q;

    // R1: an event with no hold in force is visible after the edge.
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(evt_i & ~hold_next_i)) == $past(evt_i & ~hold_next_i)));
    // R2: a set bit survives unless a hold was applied.
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q)) == ($past(status_q) & ~$past(hold_next_i))));
endmodule

// File: rtl/evt_irq_gen.sv
`timescale 1ns/1ps
// Module: evt_irq_gen
// Turns a rising edge of the masked-OR condition into a request that is
// held until the downstream generator acknowledges it. If a rise and an
// acknowledge arrive in the same cycle, the rise wins.
// Assumes: pending_i is a registered-source level synchronous to clk.
module evt_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic ack_i,
    output logic req_o
);
    logic pend_q;

    // Edge detector on the pending condition and request set/clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            req_o  <= 1'b0;
        end else begin
            pend_q <= pending_i;
            if (pending_i && !pend_q) req_o <= 1'b1;
            else if (ack_i)           req_o <= 1'b0;
        end
    end

    // R6: a raised request stays up until acknowledged.
    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);
    // R7: a request rises only after a 0 to 1 change of the condition.
    assert_rise_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ($past(pending_i) && !$past(pend_q)));
endmodule

// File: rtl/evt_status_ctrl.sv
`timescale 1ns/1ps
// Module: evt_status_ctrl (top)
// Masked event status controller. It ties together the register port, the
// sticky status bank and the interrupt request generator, and forms the
// masked-OR condition.
// Assumes: the single register clock drives everything; rst_n is synchronous.
module evt_status_ctrl #(
    parameter int                EVT_W     = 32,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1474
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [EVT_W-1:0]  reg_wdata_i,
    output logic [EVT_W-1:0]  reg_rdata_o,
    output logic              reg_ack_o,
    output logic              irq_req_o,
    input  logic              irq_ack_i
);
    logic [EVT_W-1:0] status, hold_q, hold_next, mask_q;
    logic             pending;

    evt_regport #(.EVT_W(EVT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regport (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (reg_addr_i),
        .wr_i        (reg_wr_i),
        .rd_i        (reg_rd_i),
        .wdata_i     (reg_wdata_i),
        .status_i    (status),
        .rdata_o     (reg_rdata_o),
        .ack_o       (reg_ack_o),
        .hold_q_o    (hold_q),
        .hold_next_o (hold_next),
        .mask_q_o    (mask_q)
    );

    evt_status_bank #(.EVT_W(EVT_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .hold_next_i (hold_next),
        .status_o    (status)
    );

    // Masked OR of the status bits that may reach the host.
    assign pending = |(status & ~mask_q);

    evt_irq_gen u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .ack_i     (irq_ack_i),
        .req_o     (irq_req_o)
    );

    // R4: a bit under hold always reads as 0.
    assert_hold_forces_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status & hold_q) == '0);
    // R5: a request only rises when an unmasked status bit was set.
    assert_mask_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o) |-> $past(|(status & ~mask_q)));
endmodule

// File: tb/evt_status_ctrl_bench.sv
`timescale 1ns/1ps
module evt_status_ctrl_bench;
    localparam logic [15:0] BASE = 16'h1474;
    localparam logic [15:0] A_ST = BASE;
    localparam logic [15:0] A_HD = BASE + 16'h4;
    localparam logic [15:0] A_MK = BASE + 16'h8;
    localparam logic [15:0] A_UN = BASE + 16'hC;

    typedef struct packed {
        logic [31:0] evt;
        logic [31:0] mask;
        logic [31:0] st;
        logic        irq;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1},
        '{32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1},
        '{32'h0000_00F0, 32'hFFFF_FFFF, 32'h0000_00F0, 1'b0},
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0},
        '{32'h1234_5678, 32'hFFFF_FFF7, 32'h1234_5678, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack;
    logic        irq_req;
    logic        irq_ack = 1'b0;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;
    logic [31:0] d;

    always #10 clk = ~clk;

    evt_status_ctrl u_evt_status_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .reg_ack_o(ack),
        .irq_req_o(irq_req), .irq_ack_i(irq_ack)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_evt(input logic [15:0] a, input logic [31:0] v, input logic [31:0] e);
        @(negedge clk); addr = a; wdata = v; wr = 1'b1; evt = e;
        @(negedge clk); wr = 1'b0; evt = '0;
        check(ack === 1'b1, "R9 write ack", {31'b0, ack}, 32'h1);
    endtask

    task automatic wreg(input logic [15:0] a, input logic [31:0] v);
        wr_evt(a, v, '0);
    endtask

    task automatic rreg(input logic [15:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        check(ack === 1'b1, "R9 read ack", {31'b0, ack}, 32'h1);
        v = rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk); evt = e;
        @(negedge clk); evt = '0;
    endtask

    task automatic give_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic fresh(input logic [31:0] m);
        wreg(A_HD, '1);
        wreg(A_HD, '0);
        wreg(A_MK, m);
        give_ack();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check(irq_req === 1'b0, "R10 irq after reset", {31'b0, irq_req}, 0);
        check(ack === 1'b0, "R10 ack after reset", {31'b0, ack}, 0);
        @(negedge clk);
        check(ack === 1'b0, "R9 idle ack", {31'b0, ack}, 0);
        rreg(A_ST, d); check(d === 32'h0, "R10 status reset", d, 0);
        rreg(A_HD, d); check(d === 32'h0, "R10 hold reset", d, 0);
        rreg(A_MK, d); check(d === 32'hFFFF_FFFF, "R5 mask reset ones", d, 32'hFFFF_FFFF);

        // Vector table: R1 capture, R5 masking, R6 request
        for (int i = 0; i < NV; i++) begin
            fresh(VECS[i].mask);
            pulse(VECS[i].evt);
            check(irq_req === 1'b0, "R6 request latency", {31'b0, irq_req}, 0);
            @(negedge clk);
            check(irq_req === VECS[i].irq, "R5 R6 masked request", {31'b0, irq_req}, {31'b0, VECS[i].irq});
            rreg(A_ST, d); check(d === VECS[i].st, "R1 status capture", d, VECS[i].st);
            give_ack();
        end

        // R6 hold until ack, R7 no retrigger while the condition stays high
        fresh(32'h0);
        pulse(32'h1);
        @(negedge clk);
        check(irq_req === 1'b1, "R6 raise", {31'b0, irq_req}, 1);
        repeat (3) @(negedge clk);
        check(irq_req === 1'b1, "R6 held without ack", {31'b0, irq_req}, 1);
        give_ack();
        check(irq_req === 1'b0, "R6 dropped on ack", {31'b0, irq_req}, 0);
        pulse(32'h2);
        repeat (2) @(negedge clk);
        check(irq_req === 1'b0, "R7 no retrigger", {31'b0, irq_req}, 0);
        wreg(A_HD, '1);
        wreg(A_HD, '0);
        pulse(32'h4);
        @(negedge clk);
        check(irq_req === 1'b1, "R7 rearm after fall", {31'b0, irq_req}, 1);
        give_ack();

        // R6 unmasking an already set bit raises a request
        fresh(32'hFFFF_FFFF);
        pulse(32'h200);
        repeat (2) @(negedge clk);
        check(irq_req === 1'b0, "R5 masked bit no request", {31'b0, irq_req}, 0);
        wreg(A_MK, ~32'h200);
        check(irq_req === 1'b0, "R6 unmask latency", {31'b0, irq_req}, 0);
        @(negedge clk);
        check(irq_req === 1'b1, "R6 unmask raises", {31'b0, irq_req}, 1);
        give_ack();

        // R2 sticky, R3 clear, R4 held clear
        fresh(32'hFFFF_FFFF);
        pulse(32'h8);
        rreg(A_ST, d); check(d === 32'h8, "R2 set", d, 32'h8);
        rreg(A_ST, d); check(d === 32'h8, "R2 read no side effect", d, 32'h8);
        wreg(A_HD, 32'h8);
        rreg(A_ST, d); check(d === 32'h0, "R3 write one clears", d, 0);
        pulse(32'h8);
        rreg(A_ST, d); check(d === 32'h0, "R4 event ignored under hold", d, 0);
        rreg(A_HD, d); check(d === 32'h8, "R4 hold readback", d, 32'h8);
        wreg(A_HD, 32'h0);
        pulse(32'h8);
        rreg(A_ST, d); check(d === 32'h8, "R4 re-enabled", d, 32'h8);
        wr_evt(A_HD, 32'h20, 32'h20);
        rreg(A_ST, d); check(d === 32'h8, "R4 clear wins same cycle", d, 32'h8);
        wr_evt(A_HD, 32'h0, 32'h20);
        rreg(A_ST, d); check(d === 32'h28, "R4 capture on release cycle", d, 32'h28);

        // R8 address map
        wreg(A_ST, 32'h0);
        rreg(A_ST, d); check(d === 32'h28, "R8 status write ignored", d, 32'h28);
        wreg(A_UN, 32'h1234);
        rreg(A_MK, d); check(d === 32'hFFFF_FFFF, "R8 unmapped write mask", d, 32'hFFFF_FFFF);
        rreg(A_HD, d); check(d === 32'h0, "R8 unmapped write hold", d, 0);
        rreg(A_UN, d); check(d === 32'h0, "R8 unmapped read zero", d, 0);

        // R10 mid-run reset
        wreg(A_MK, 32'h0);
        wreg(A_HD, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(irq_req === 1'b0, "R10 irq cleared", {31'b0, irq_req}, 0);
        rreg(A_ST, d); check(d === 32'h0, "R10 status cleared", d, 0);
        rreg(A_HD, d); check(d === 32'h0, "R10 hold cleared", d, 0);
        rreg(A_MK, d); check(d === 32'hFFFF_FFFF, "R10 mask ones", d, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule